// File: doc/BRIEF.md
# Four-Channel DMA Programming Register File

This block is the host-side register file of a four-channel DMA controller in the classic PC arrangement. A host issues 8-bit writes and reads on an 8-bit port space. Through them it programs each channel's 16-bit start address, its 16-bit transfer count and its 6-bit operating mode. It also sets or clears each channel's mask bit and loads an 8-bit page value that forms address bits 23:16. Sixteen-bit values pass through the 8-bit port as two accesses, low byte first. A single byte-order toggle shared by all channels tracks which byte comes next, and a dedicated port forces it back to "low".

The programmed state of every channel appears on flat output vectors for a transfer engine to use. The engine advances a channel with a one-cycle step pulse. Each pulse decrements the count and moves the address up or down. When the count underflows, the channel raises terminal count. It then either reloads its start values or masks itself. A status read returns the terminal-count flags and clears them.

Top module: `dma_regfile`

## Requirements
- R1: After reset all four mask bits are 1, the byte-order toggle selects the low byte, and every mode, page, address, count and terminal-count flag is zero.
- R2: Channel n's address port is at 2n and its count port at 2n+1 (n = 0..3). A write loads the low byte when the toggle selects low and the high byte otherwise. It updates both the start copy and the working copy.
- R3: A write to port 0x0C returns the toggle to "low" whatever the data.
- R4: Every read or write of ports 0x00-0x07 flips the toggle. A read returns the working address or count, low byte then high byte.
- R5: A write to port 0x0B stores data bits 7:2 as the mode of the channel named by data bits 1:0. In the stored field, bits 5:4 are the transfer style, bit 3 is 1 for address decrement, bit 2 is 1 for auto-reload and bits 1:0 are the transfer type.
- R6: A mode write whose transfer type (data bits 3:2) is 11 is discarded: the stored mode is unchanged and `mode_err` is 1 for exactly the next cycle.
- R7: A write to port 0x0A sets (data bit 2 = 1) or clears (bit 2 = 0) the mask of the channel named by data bits 1:0. The other masks are unaffected.
- R8: Page ports 0x87, 0x83, 0x81 and 0x82 belong to channels 0..3. They are readable and drive `ch_addr` bits 23:16. The page never changes when the 16-bit address wraps.
- R9: A step on an unmasked channel decrements its working count and adds 1 to the working address, or subtracts 1 when mode bit 3 is set. A step on a masked channel changes nothing.
- R10: A programmed count of N gives N+1 steps. `tc` is high during the step taken while the count is 0, and during no other step.
- R11: At terminal count, a channel with auto-reload copies its start address and count into the working copies and stays unmasked. A channel without auto-reload wraps its count to 0xFFFF and sets its mask.
- R12: A read of port 0x08 returns the terminal-count flags in bits 3:0 (bit n for channel n) and clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| rd_en | input | 1 | Host read strobe, one cycle per byte |
| addr | input | 8 | Port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| step | input | 4 | One-cycle advance pulse per channel |
| ch_addr | output | 4x24 | Per channel: page and working address |
| ch_count | output | 4x16 | Per channel: working count |
| ch_mode | output | 4x6 | Per channel: stored mode field |
| ch_mask | output | 4 | Per channel mask, 1 = disabled |
| tc | output | 4 | Per channel terminal-count pulse |
| mode_err | output | 1 | One-cycle flag for a discarded mode write |

## Verification
The bound checker watches several rules on every cycle. It checks that the clear port always leaves the toggle at "low" and that each channel-port access flips it. It also checks that an illegal mode write leaves all modes untouched and raises `mode_err`. Further rules cover masked steps, which freeze the channel, pages, which move only on their own port, terminal count, which fires only at count zero, and channels without auto-reload, which mask themselves at terminal count. The exact byte sequences, the read-back order, the N+1 step length, the reload values and the clear-on-read status need the bench's directed scenarios.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

  localparam logic [7:0] PORT_MASK  = 8'h0A;
  localparam logic [7:0] PORT_MODE  = 8'h0B;
  localparam logic [7:0] PORT_CLEAR = 8'h0C;
  localparam logic [7:0] PORT_STAT  = 8'h08;

  // Stored mode field: data bits 7:2 of a mode write
  typedef struct packed {
    logic [1:0] style;
    logic       dec;
    logic       reload;
    logic [1:0] xtype;
  } mode_t;

  localparam logic [1:0] XTYPE_BAD = 2'b11;

  function automatic logic [7:0] page_port(input int ch);
    case (ch)
      0:       page_port = 8'h87;
      1:       page_port = 8'h83;
      2:       page_port = 8'h81;
      default: page_port = 8'h82;
    endcase
  endfunction

endpackage

// File: rtl/dma_rf_byteptr.sv
module dma_rf_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tgl,
  output logic hi
);
  logic hi_q, hi_d;

  always_comb begin
    hi_d = hi_q;
    if (clr)      hi_d = 1'b0;
    else if (tgl) hi_d = ~hi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_q <= 1'b0;
    else        hi_q <= hi_d;
  end

  assign hi = hi_q;
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
  import dma_rf_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic          hi_sel,
  input  logic          ld_page,
  input  logic          ld_mode,
  input  logic          mask_wr,
  input  logic          mask_val,
  input  logic [DW-1:0] wdata,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic [PW-1:0] page,
  output mode_t         mode,
  output logic          mask,
  output logic          tc
);
  logic [AW-1:0] base_addr_q, base_addr_d, cur_addr_q, cur_addr_d;
  logic [CW-1:0] base_cnt_q, base_cnt_d, cur_cnt_q, cur_cnt_d;
  logic [PW-1:0] page_q, page_d;
  mode_t         mode_q, mode_d;
  logic          mask_q, mask_d;
  logic          go, wrap;

  assign go   = step && !mask_q;
  assign wrap = (cur_cnt_q == '0);
  assign tc   = go && wrap;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    cur_addr_d  = cur_addr_q;
    cur_cnt_d   = cur_cnt_q;
    page_d      = page_q;
    mode_d      = mode_q;
    mask_d      = mask_q;
    // transfer advance
    if (go) begin
      cur_cnt_d  = cur_cnt_q - 1'b1;
      cur_addr_d = mode_q.dec ? cur_addr_q - 1'b1 : cur_addr_q + 1'b1;
      if (wrap) begin
        if (mode_q.reload) begin
          cur_addr_d = base_addr_q;
          cur_cnt_d  = base_cnt_q;
        end else begin
          mask_d = 1'b1;
        end
      end
    end
    // host writes take priority over a same-cycle advance
    if (ld_addr) begin
      if (hi_sel) base_addr_d = {wdata, base_addr_q[DW-1:0]};
      else        base_addr_d = {base_addr_q[AW-1:DW], wdata};
      cur_addr_d = base_addr_d;
    end
    if (ld_cnt) begin
      if (hi_sel) base_cnt_d = {wdata, base_cnt_q[DW-1:0]};
      else        base_cnt_d = {base_cnt_q[CW-1:DW], wdata};
      cur_cnt_d = base_cnt_d;
    end
    if (ld_page) page_d = wdata[PW-1:0];
    if (ld_mode) mode_d = mode_t'(wdata[7:2]);
    if (mask_wr) mask_d = mask_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      page_q      <= '0;
      mode_q      <= '0;
      mask_q      <= 1'b1;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      cur_addr_q  <= cur_addr_d;
      cur_cnt_q   <= cur_cnt_d;
      page_q      <= page_d;
      mode_q      <= mode_d;
      mask_q      <= mask_d;
    end
  end

  assign cur_addr = cur_addr_q;
  assign cur_cnt  = cur_cnt_q;
  assign page     = page_q;
  assign mode     = mode_q;
  assign mask     = mask_q;
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int PW  = 8,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [7:0]             addr,
  input  logic [DW-1:0]          wdata,
  output logic [DW-1:0]          rdata,
  input  logic [NCH-1:0]         step,
  output logic [NCH-1:0][AW+PW-1:0] ch_addr,
  output logic [NCH-1:0][CW-1:0] ch_count,
  output logic [NCH-1:0][5:0]    ch_mode,
  output logic [NCH-1:0]         ch_mask,
  output logic [NCH-1:0]         tc,
  output logic                   mode_err
);
  localparam int CHW = $clog2(NCH);

  logic           acc_chan, is_cnt, ptr_hi;
  logic [CHW-1:0] ch_sel;
  logic           wr_clr, wr_mode, wr_mask, rd_stat, mode_ok;
  logic [NCH-1:0] flags_q, flags_d;
  logic           merr_q, merr_d;
  logic [NCH-1:0][AW-1:0] cur_addr;
  logic [NCH-1:0][PW-1:0] page;

  assign acc_chan = (addr < 8'(2 * NCH));
  assign ch_sel   = addr[CHW:1];
  assign is_cnt   = addr[0];
  assign wr_clr   = wr_en && (addr == PORT_CLEAR);
  assign wr_mode  = wr_en && (addr == PORT_MODE);
  assign wr_mask  = wr_en && (addr == PORT_MASK);
  assign rd_stat  = rd_en && !wr_en && (addr == PORT_STAT);
  assign mode_ok  = (wdata[3:2] != XTYPE_BAD);

  dma_rf_byteptr u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (wr_clr),
    .tgl  ((wr_en || rd_en) && acc_chan),
    .hi   (ptr_hi)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic  sel_ch, sel_ctl;
    mode_t mode_i;
    assign sel_ch  = wr_en && acc_chan && (ch_sel == CHW'(i));
    assign sel_ctl = (wdata[CHW-1:0] == CHW'(i));

    dma_rf_chan #(.AW(AW), .CW(CW), .PW(PW), .DW(DW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_addr (sel_ch && !is_cnt),
      .ld_cnt  (sel_ch && is_cnt),
      .hi_sel  (ptr_hi),
      .ld_page (wr_en && (addr == page_port(i))),
      .ld_mode (wr_mode && mode_ok && sel_ctl),
      .mask_wr (wr_mask && sel_ctl),
      .mask_val(wdata[2]),
      .wdata   (wdata),
      .step    (step[i]),
      .cur_addr(cur_addr[i]),
      .cur_cnt (ch_count[i]),
      .page    (page[i]),
      .mode    (mode_i),
      .mask    (ch_mask[i]),
      .tc      (tc[i])
    );
    assign ch_mode[i] = mode_i;
    assign ch_addr[i] = {page[i], cur_addr[i]};
  end

  always_comb begin
    flags_d = (rd_stat ? '0 : flags_q) | tc;
    merr_d  = wr_mode && !mode_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      merr_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      merr_q  <= merr_d;
    end
  end

  assign mode_err = merr_q;

  always_comb begin
    rdata = '0;
    if (acc_chan) begin
      if (is_cnt) rdata = ptr_hi ? ch_count[ch_sel][CW-1:DW] : ch_count[ch_sel][DW-1:0];
      else        rdata = ptr_hi ? cur_addr[ch_sel][AW-1:DW] : cur_addr[ch_sel][DW-1:0];
    end else if (addr == PORT_STAT) begin
      rdata = DW'(flags_q);
    end
    for (int i = 0; i < NCH; i++) begin
      if (addr == page_port(i)) rdata = DW'(page[i]);
    end
  end

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
  import dma_rf_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  parameter int PW  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic                      rd_en,
  input logic [7:0]                addr,
  input logic [7:0]                wdata,
  input logic [NCH-1:0]            step,
  input logic [NCH-1:0][AW+PW-1:0] ch_addr,
  input logic [NCH-1:0][CW-1:0]    ch_count,
  input logic [NCH-1:0][5:0]       ch_mode,
  input logic [NCH-1:0]            ch_mask,
  input logic [NCH-1:0]            tc,
  input logic                      mode_err,
  input logic                      ptr_hi
);
  assert_clear_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == PORT_CLEAR |=> !ptr_hi);

  assert_toggle_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && addr < 8'(2 * NCH) |=> ptr_hi != $past(ptr_hi));

  assert_bad_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == PORT_MODE && wdata[3:2] == XTYPE_BAD |=> mode_err && $stable(ch_mode));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_masked_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step[i] && ch_mask[i] && !wr_en |=> $stable(ch_count[i]) && $stable(ch_addr[i]));

    assert_page_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == page_port(i)) |=> $stable(ch_addr[i][AW+PW-1:AW]));

    assert_tc_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tc[i] |-> step[i] && ch_count[i] == '0 && !ch_mask[i]);

    assert_tc_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tc[i] && !ch_mode[i][2] && !wr_en |=> ch_mask[i]);
  end
endmodule

bind dma_regfile dma_regfile_chk #(.NCH(NCH), .AW(AW), .CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .step(step), .ch_addr(ch_addr), .ch_count(ch_count),
  .ch_mode(ch_mode), .ch_mask(ch_mask), .tc(tc), .mode_err(mode_err),
  .ptr_hi(ptr_hi)
);

// File: tb/dma_regfile_bench.sv
module dma_regfile_bench;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]        addr = '0, wdata = '0;
  logic [7:0]        rdata;
  logic [3:0]        step = '0;
  logic [3:0][23:0]  ch_addr;
  logic [3:0][15:0]  ch_count;
  logic [3:0][5:0]   ch_mode;
  logic [3:0]        ch_mask, tc;
  logic              mode_err;
  int                nchk = 0, nfail = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  dma_regfile u_dma_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .step(step), .ch_addr(ch_addr),
    .ch_count(ch_count), .ch_mode(ch_mode), .ch_mask(ch_mask), .tc(tc),
    .mode_err(mode_err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input int ch, output logic t);
    @(negedge clk); step[ch] = 1'b1;
    #1 t = tc[ch];
    @(negedge clk); step[ch] = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 masks", ch_mask, 4'hF);
    chk("R1 modes", ch_mode, 24'h0);
    chk("R1 count", ch_count[3], 16'h0);
    rd(8'h00, d); chk("R1 addr lo", d, 8'h00);
    rd(8'h08, d); chk("R1 status", d, 8'h00);
  endtask

  task automatic t_load;
    wr(8'h0C, 8'h00);
    wr(8'h02, 8'h34); wr(8'h02, 8'h12);
    chk("R2 ch1 addr", ch_addr[1][15:0], 16'h1234);
    wr(8'h03, 8'h05); wr(8'h03, 8'h00);
    chk("R2 ch1 count", ch_count[1], 16'h0005);
  endtask

  task automatic t_clear;
    wr(8'h04, 8'hAA);
    wr(8'h0C, 8'hFF);
    wr(8'h04, 8'h55); wr(8'h04, 8'h66);
    chk("R3 clear resyncs low byte", ch_addr[2][15:0], 16'h6655);
  endtask

  task automatic t_readback;
    logic [7:0] d;
    wr(8'h0C, 8'h00);
    rd(8'h02, d); chk("R4 read lo", d, 8'h34);
    rd(8'h02, d); chk("R4 read hi", d, 8'h12);
    rd(8'h03, d); chk("R4 count lo", d, 8'h05);
  endtask

  task automatic t_mode;
    wr(8'h0B, 8'h75);
    chk("R5 ch1 mode", ch_mode[1], 6'h1D);
    chk("R5 ch0 untouched", ch_mode[0], 6'h00);
  endtask

  task automatic t_illegal;
    wr(8'h0B, 8'h4D);
    chk("R6 flag", mode_err, 1'b1);
    chk("R6 mode kept", ch_mode[1], 6'h1D);
    @(negedge clk);
    chk("R6 flag one cycle", mode_err, 1'b0);
  endtask

  task automatic t_mask;
    wr(8'h0A, 8'h01); chk("R7 clear ch1", ch_mask, 4'hD);
    wr(8'h0A, 8'h02); chk("R7 clear ch2", ch_mask, 4'h9);
    wr(8'h0A, 8'h06); chk("R7 set ch2", ch_mask, 4'hD);
  endtask

  task automatic t_page;
    logic [7:0] d;
    wr(8'h83, 8'h12);
    chk("R8 page ch1", ch_addr[1][23:16], 8'h12);
    rd(8'h83, d); chk("R8 page read", d, 8'h12);
    chk("R8 other page", ch_addr[0][23:16], 8'h00);
  endtask

  task automatic t_step;
    logic t;
    pulse(1, t);
    chk("R9 count dec", ch_count[1], 16'h0004);
    chk("R9 addr dec", ch_addr[1], 24'h121233);
    pulse(2, t);
    chk("R9 masked ignored", {ch_count[2], ch_addr[2][15:0]}, {16'h0000, 16'h6655});
  endtask

  task automatic t_autoinit;
    logic t;
    int tcs = 0;
    for (int k = 0; k < 4; k++) begin
      pulse(1, t); if (t) tcs++;
    end
    chk("R10 no early tc", tcs, 0);
    chk("R10 count at zero", ch_count[1], 16'h0000);
    pulse(1, t);
    chk("R10 tc on step N+1", t, 1'b1);
    chk("R11 reload count", ch_count[1], 16'h0005);
    chk("R11 reload addr", ch_addr[1], 24'h121234);
    chk("R11 stays unmasked", ch_mask[1], 1'b0);
  endtask

  task automatic t_single;
    logic t;
    wr(8'h87, 8'h40);
    wr(8'h0C, 8'h00);
    wr(8'h00, 8'hFF); wr(8'h00, 8'hFF);
    wr(8'h01, 8'h01); wr(8'h01, 8'h00);
    wr(8'h0B, 8'h44);
    wr(8'h0A, 8'h00);
    pulse(0, t);
    chk("R8 wrap keeps page", ch_addr[0], 24'h400000);
    chk("R10 no tc at count 1", t, 1'b0);
    pulse(0, t);
    chk("R10 tc ch0", t, 1'b1);
    chk("R11 wrap count", ch_count[0], 16'hFFFF);
    chk("R11 masked", ch_mask[0], 1'b1);
    pulse(0, t);
    chk("R9 step after mask ignored", ch_count[0], 16'hFFFF);
  endtask

  task automatic t_status;
    logic [7:0] d;
    rd(8'h08, d); chk("R12 flags", d, 8'h03);
    rd(8'h08, d); chk("R12 cleared", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load;
    t_clear;
    t_readback;
    t_mode;
    t_illegal;
    t_mask;
    t_page;
    t_step;
    t_autoinit;
    t_single;
    t_status;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule